// File: doc/BRIEF.md
# Common Interrupt Destination Router

This block is the shared distributor stage of a multiprocessor interrupt controller. Each common interrupt line has a word-wide destination register. The register holds a delivery enable flag and the index of one target core. The router passes the level of every common interrupt to the pending vector of the core that its register names. If the enable flag is clear, or the named core does not exist, the interrupt goes to no core.

Software programs the registers through a simple 32-bit read/write port inside a 32 KiB register window. Common interrupt numbers start at 32. Table entry k therefore serves interrupt number k+32, and its register sits at byte offset 0x1000 + 4*k. Reads are combinational from the address. A write lands on the next rising clock edge. Priority, claiming and broadcast delivery belong to other stages.

Top module: `irq_dest_router`

## Requirements
- R1: After reset every destination register reads as zero and no core has any pending interrupt, whatever the interrupt inputs are.
- R2: The register for table entry k (interrupt number k+32) is at byte offset 0x1000 + 4*k for k below N_COMMON. Address bits [1:0] are ignored.
- R3: When entry k has bit 31 set and its core field (bits [7:0]) is below N_CORES, that core's pending bit k follows the level of interrupt input k. Bit k is zero for every other core.
- R4: When bit 31 of entry k is clear, interrupt k is pending at no core.
- R5: When the core field of entry k is N_CORES or more, interrupt k is pending at no core, even with bit 31 set.
- R6: A read of entry k returns bit 31 and bits [7:0] as last written. Bits [30:8] read as zero.
- R7: A write changes routing from the cycle after the clock edge that accepts it. Before that edge the old routing holds.
- R8: Accesses outside the table (below 0x1000, or at 0x1000 + 4*N_COMMON and above) read zero. Writes there change no register.
- R9: Each interrupt is pending at no more than one core at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address inside the 32 KiB window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_in | input | N_COMMON | Common interrupt levels, bit k = interrupt k+32 |
| core_pend | output | N_CORES x N_COMMON | Pending vector per core, [core][entry] |

## Verification
Several properties are checked on every cycle by assertions:
- each interrupt reaches at most one core;
- a disabled or out-of-range entry never shows as pending;
- a register port write lands in the addressed entry;
- the table stays still when no write hits it;
- misses and unused bits read zero.

Other behaviour can only be shown by the bench's scenarios:
- the exact address-to-entry mapping, including ignored low bits and the last entry;
- that routing follows live interrupt levels to the correct core;
- the old routing holding until the accepting edge;
- the reset state seen through the read port.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    // Width of the stored target core field
    localparam int CORE_FIELD_W = 8;
    // Bit that enables delivery in a destination word
    localparam int DEST_EN_BIT  = 31;
    // First destination register, byte offset in the window
    localparam int unsigned DEST_BASE = 32'h0000_1000;
    // Total global register window size in bytes
    localparam int unsigned WINDOW_BYTES = 32'h0000_8000;
    // First common interrupt number
    localparam int FIRST_COMMON_ID = 32;

    typedef struct packed {
        logic                    en;
        logic [CORE_FIELD_W-1:0] core;
    } dest_t;

endpackage

// File: rtl/irq_dest_decode.sv
module irq_dest_decode
    import irq_router_pkg::*;
#(
    parameter int N_COMMON = 64,
    parameter int ADDR_W   = 15,
    localparam int IDX_W   = (N_COMMON > 1) ? $clog2(N_COMMON) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam int unsigned TABLE_END = DEST_BASE + 4 * N_COMMON;

    logic [31:0] addr32;
    logic [31:0] offset;

    always_comb begin
        addr32 = 32'(addr_i);
        offset = addr32 - DEST_BASE;
        hit_o  = (addr32 >= DEST_BASE) && (addr32 < TABLE_END);
        idx_o  = offset[IDX_W+1:2];
    end

endmodule

// File: rtl/irq_dest_table.sv
module irq_dest_table
    import irq_router_pkg::*;
#(
    parameter int N_COMMON = 64,
    localparam int IDX_W   = (N_COMMON > 1) ? $clog2(N_COMMON) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_i,
    input  logic                      hit_i,
    input  logic [IDX_W-1:0]          idx_i,
    input  logic [31:0]               wdata_i,
    output logic [31:0]               rdata_o,
    output dest_t [N_COMMON-1:0]      tbl_o
);
    typedef struct packed {
        dest_t [N_COMMON-1:0] tbl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i && hit_i) begin
            st_d.tbl[idx_i].en   = wdata_i[DEST_EN_BIT];
            st_d.tbl[idx_i].core = wdata_i[CORE_FIELD_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (hit_i) begin
            rdata_o[DEST_EN_BIT]         = st_q.tbl[idx_i].en;
            rdata_o[CORE_FIELD_W-1:0]    = st_q.tbl[idx_i].core;
        end
    end

    assign tbl_o = st_q.tbl;

    // R7: an accepted write is visible in the addressed entry next cycle
    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && hit_i) |=> (st_q.tbl[$past(idx_i)].en == $past(wdata_i[DEST_EN_BIT])));

    // R8: with no write hitting the table, nothing in it moves
    a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && hit_i) |=> $stable(st_q));

    // R6: unused bits of a destination read back as zero
    a_r6_read_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |-> (rdata_o[DEST_EN_BIT-1:CORE_FIELD_W] == '0));

endmodule

// File: rtl/irq_dest_fanout.sv
module irq_dest_fanout
    import irq_router_pkg::*;
#(
    parameter int N_COMMON = 64,
    parameter int N_CORES  = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  dest_t [N_COMMON-1:0]             tbl_i,
    input  logic  [N_COMMON-1:0]             irq_i,
    output logic  [N_CORES-1:0][N_COMMON-1:0] pend_o
);
    // Per-interrupt view across cores, for the checks below
    logic [N_COMMON-1:0][N_CORES-1:0] col;

    for (genvar c = 0; c < N_CORES; c++) begin : g_core
        for (genvar i = 0; i < N_COMMON; i++) begin : g_irq
            always_comb begin
                pend_o[c][i] = irq_i[i] && tbl_i[i].en &&
                               (tbl_i[i].core == CORE_FIELD_W'(c));
            end
            assign col[i][c] = pend_o[c][i];
        end
    end

    for (genvar i = 0; i < N_COMMON; i++) begin : g_chk
        // R9: at most one target per interrupt
        a_r9_single_target: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col[i]));
        // R4: disabled entries deliver nowhere
        a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !tbl_i[i].en |-> (col[i] == '0));
        // R5: a target beyond the core count delivers nowhere
        a_r5_bad_core_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (32'(tbl_i[i].core) >= N_CORES) |-> (col[i] == '0));
    end

endmodule

// File: rtl/irq_dest_router.sv
module irq_dest_router
    import irq_router_pkg::*;
#(
    parameter int N_COMMON = 64,
    parameter int N_CORES  = 4,
    parameter int ADDR_W   = 15
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_wr,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic [31:0]                       reg_wdata,
    output logic [31:0]                       reg_rdata,
    input  logic [N_COMMON-1:0]               irq_in,
    output logic [N_CORES-1:0][N_COMMON-1:0]  core_pend
);
    localparam int IDX_W = (N_COMMON > 1) ? $clog2(N_COMMON) : 1;

    logic                  hit;
    logic [IDX_W-1:0]      idx;
    dest_t [N_COMMON-1:0]  tbl;

    irq_dest_decode #(.N_COMMON(N_COMMON), .ADDR_W(ADDR_W)) u_decode (
        .addr_i (reg_addr),
        .hit_o  (hit),
        .idx_o  (idx)
    );

    irq_dest_table #(.N_COMMON(N_COMMON)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .hit_i   (hit),
        .idx_i   (idx),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .tbl_o   (tbl)
    );

    irq_dest_fanout #(.N_COMMON(N_COMMON), .N_CORES(N_CORES)) u_fanout (
        .clk    (clk),
        .rst_n  (rst_n),
        .tbl_i  (tbl),
        .irq_i  (irq_in),
        .pend_o (core_pend)
    );

    // R8: addresses outside the table read zero
    a_r8_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (reg_rdata == 32'h0));

endmodule

// File: tb/sim_irq_dest_router.sv
`timescale 1ns/1ps
module sim_irq_dest_router;
    localparam int NC   = 64;
    localparam int NK   = 4;
    localparam int AW   = 15;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      reg_wr = 1'b0;
    logic [AW-1:0]             reg_addr = '0;
    logic [31:0]               reg_wdata = '0;
    logic [31:0]               reg_rdata;
    logic [NC-1:0]             irq_in = '0;
    logic [NK-1:0][NC-1:0]     core_pend;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    bit       m_en   [NC];
    bit [7:0] m_core [NC];

    always #2.5 clk = ~clk;

    irq_dest_router #(.N_COMMON(NC), .N_CORES(NK), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
        .core_pend(core_pend)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NC-1:0] exp_pend(input int c);
        logic [NC-1:0] v = '0;
        for (int i = 0; i < NC; i++)
            v[i] = irq_in[i] && m_en[i] && (int'(m_core[i]) == c);
        return v;
    endfunction

    function automatic logic [31:0] exp_word(input int k);
        return {m_en[k], 23'h0, m_core[k]};
    endfunction

    task automatic check_routes(input string req);
        for (int c = 0; c < NK; c++)
            check(core_pend[c] == exp_pend(c), req, 64'(core_pend[c]), 64'(exp_pend(c)));
        for (int i = 0; i < NC; i++) begin
            int n = 0;
            for (int c = 0; c < NK; c++) n += int'(core_pend[c][i]);
            if (n > 1) check(0, "R9", 64'(n), 64'd1);
        end
        checks++; // R9 column count pass
    endtask

    task automatic write_reg(input logic [AW-1:0] a, input logic [31:0] d);
        int off;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        #1;
        check_routes("R7 old routing before edge");
        @(negedge clk);
        reg_wr = 1'b0;
        off = int'(a) - 32'h1000;
        if (off >= 0 && off < 4 * NC) begin
            m_en[off/4]   = d[31];
            m_core[off/4] = d[7:0];
        end
        #1;
    endtask

    task automatic read_check(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic read_table(input string req);
        for (int k = 0; k < NC; k++)
            read_check(AW'(32'h1000 + 4 * k), exp_word(k), req);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234));
        for (int k = 0; k < NC; k++) begin m_en[k] = 0; m_core[k] = 0; end
        irq_in = '1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_routes("R1 reset pend");
        read_table("R1 reset readback");
        rst_n = 1'b1;
        @(negedge clk);
        check_routes("R1 after reset pend");

        // R3: enabled, valid core
        write_reg(AW'(32'h1000 + 4 * 5), 32'h8000_0002);
        check(core_pend[2][5] == 1'b1, "R3 routed", 64'(core_pend[2][5]), 64'd1);
        check_routes("R3 routing");
        irq_in[5] = 1'b0; #1;
        check(core_pend[2][5] == 1'b0, "R3 level follows", 64'(core_pend[2][5]), 64'd0);
        irq_in = '1; #1;

        // R4: enable clear
        write_reg(AW'(32'h1000 + 4 * 6), 32'h0000_0001);
        check(core_pend[1][6] == 1'b0, "R4 disabled", 64'(core_pend[1][6]), 64'd0);
        check_routes("R4 routing");

        // R5: core at and above count
        write_reg(AW'(32'h1000 + 4 * 7), 32'h8000_0004);
        check_routes("R5 core==N_CORES");
        write_reg(AW'(32'h1000 + 4 * 8), 32'h8000_00C8);
        check_routes("R5 core=200");

        // R6: readback masks unused bits
        write_reg(AW'(32'h1000 + 4 * 10), 32'h7FFF_FF83);
        read_check(AW'(32'h1000 + 4 * 10), 32'h0000_0083, "R6 readback");
        write_reg(AW'(32'h1000 + 4 * 11), 32'hFFFF_FF01);
        read_check(AW'(32'h1000 + 4 * 11), 32'h8000_0001, "R6 readback en");

        // R2: low address bits ignored, last entry
        write_reg(AW'(32'h1000 + 4 * 9 + 2), 32'h8000_0003);
        read_check(AW'(32'h1000 + 4 * 9), 32'h8000_0003, "R2 low bits ignored");
        write_reg(AW'(32'h1000 + 4 * (NC - 1)), 32'h8000_0001);
        read_check(AW'(32'h1000 + 4 * (NC - 1) + 3), 32'h8000_0001, "R2 last entry");
        check(core_pend[1][NC-1] == 1'b1, "R2 last entry routed", 64'(core_pend[1][NC-1]), 64'd1);

        // R8: misses
        write_reg(AW'(32'h0FFC), 32'h8000_0001);
        write_reg(AW'(32'h1000 + 4 * NC), 32'h8000_0002);
        write_reg(AW'(32'h7FFC), 32'h8000_0003);
        read_check(AW'(32'h0FFC), 32'h0, "R8 below table");
        read_check(AW'(32'h1000 + 4 * NC), 32'h0, "R8 past table");
        read_check(AW'(32'h7FFC), 32'h0, "R8 window top");
        read_table("R8 table untouched");
        check_routes("R8 routing untouched");

        // Random mix
        for (int n = 0; n < 300; n++) begin
            int k = $urandom_range(NC + 3, 0);
            logic [31:0] d = $urandom;
            d[7:0] = 8'($urandom_range(5, 0));
            irq_in = {$urandom, $urandom};
            write_reg(AW'(32'h1000 + 4 * k), d);
            check_routes("R3/R4/R5 random routing");
            if (k < NC) read_check(AW'(32'h1000 + 4 * k), exp_word(k), "R6 random readback");
        end
        read_table("R6 final table");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule